// File: doc/BRIEF.md
# Dual Comparator Trigger and Breakpoint Unit

This block watches a stream of bus cycles. Each valid cycle carries an address and a data value. Two compare values, A and B, are tested against every cycle. In debug mode the comparator results feed a trigger combiner, which can also track event order. The combiner produces a one-shot trigger pulse and a capture strobe, which a trace store downstream can use. In breakpoint mode the same comparators raise a request, either for background debug entry or for a software interrupt. One control input chooses the mode, so only one of the two output groups can ever be active.

The unit is active only while `arm_i` is high. Lowering `arm_i` clears all sequence history. Every output is registered: a bus cycle sampled at clock edge k shows its effect during the cycle after edge k. Compare value A is always an address. B is an address in every use except the full-match uses, where its low `DW` bits hold a data value.

Top module: `dbg_trig_unit`

## Requirements
- R1: After reset, `trig_o`, `cap_o`, `bgnd_req_o` and `swi_req_o` are all low.
- R2: With `brk_mode_i`=1, `trig_o` and `cap_o` stay low. With `brk_mode_i`=0, `bgnd_req_o` and `swi_req_o` stay low.
- R3: Trigger type 0 (A only) fires on a bus address equal to A. Type 1 (A or B) fires on an address equal to A or to B. In debug mode `trig_o` pulses for one cycle, the cycle after the qualifying bus cycle, and at most once per arming.
- R4: Type 2 (A then B) fires only on a B address match in a cycle later than an earlier A address match. A B match before any A match does not fire, and neither does a B match in the same cycle as the first A match.
- R5: Type 3 (event-only B) pulses `cap_o` on every B address match and never pulses `trig_o`.
- R6: Type 4 (A then event-only B) pulses `trig_o` on the first A match. After that, it pulses `cap_o` on every later B match.
- R7: Type 5 (A and B) fires when the address equals A and the data equals B[DW-1:0]. Type 6 (A and not B) fires when the address equals A and the data differs from B[DW-1:0].
- R8: Type 7 (inside) fires when A <= address <= B. Type 8 (outside) fires when the address is < A or > B. Both bounds are inclusive.
- R9: In dual-address breakpoint mode (`brk_full_i`=0), an address equal to A or to B raises a request the next cycle, on every hit.
- R10: In full breakpoint mode (`brk_full_i`=1), a request is raised only when the address equals A and the data equals B[DW-1:0].
- R11: A breakpoint hit raises `bgnd_req_o` when `brk_bgnd_i`=1 and `swi_req_o` when `brk_bgnd_i`=0. The two are never high together.
- R12: While `arm_i` is low, all outputs stay low and the sequence history is cleared. After re-arming, an A-then type needs a new A match.
- R13: Cycles with `bus_vld_i`=0 have no effect on the outputs or on the sequence history.
- R14: Trigger type codes 9 to 15 never trigger or capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| arm_i | input | 1 | Enables the unit; low clears the sequence history |
| brk_mode_i | input | 1 | 1 = breakpoint mode, 0 = debug (trigger) mode |
| trig_type_i | input | 4 | Trigger type code, 0 to 8 |
| brk_full_i | input | 1 | Breakpoint style: 1 = address and data, 0 = either address |
| brk_bgnd_i | input | 1 | Breakpoint target: 1 = background entry, 0 = software interrupt |
| cmp_a_i | input | AW | Compare value A (address) |
| cmp_b_i | input | AW | Compare value B (address, or data in its low DW bits) |
| bus_vld_i | input | 1 | Bus cycle valid |
| bus_addr_i | input | AW | Bus cycle address |
| bus_data_i | input | DW | Bus cycle data |
| trig_o | output | 1 | One-cycle trigger pulse |
| cap_o | output | 1 | Data-capture strobe |
| bgnd_req_o | output | 1 | Background debug entry request |
| swi_req_o | output | 1 | Software interrupt request |

## Verification
Each trigger type is driven with an address that matches only B, only A, both, and neither. This separates the types that combine matches with OR from the ordered ones, and from the ones that depend on data. The ordered types also get a B-before-A sequence and an A equal to B that matches in one cycle; these expose any sequencer that counts the current cycle as "earlier". Range types are probed at each bound and one step beyond it, to confirm that both bounds are inclusive. Full types are given a correct address with data off by one. Breakpoint mode reuses the same address patterns with the trigger type still set, which shows that the two modes stay exclusive and that the request target follows its select input.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;

  typedef enum logic [3:0] {
    TT_A_ONLY      = 4'd0,
    TT_A_OR_B      = 4'd1,
    TT_A_THEN_B    = 4'd2,
    TT_EV_B        = 4'd3,
    TT_A_THEN_EV_B = 4'd4,
    TT_A_AND_B     = 4'd5,
    TT_A_NOT_B     = 4'd6,
    TT_INSIDE      = 4'd7,
    TT_OUTSIDE     = 4'd8
  } trig_type_e;

  typedef struct packed {
    logic a_addr;
    logic b_addr;
    logic b_data;
    logic in_rng;
  } cmp_hits_t;

endpackage

// File: rtl/dbg_cmp.sv
module dbg_cmp
  import dbg_trig_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic [AW-1:0] a_val_i,
  input  logic [AW-1:0] b_val_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output cmp_hits_t     hits_o
);

  logic [DW-1:0] b_data;

  generate
    if (DW == AW) begin : g_full_width
      assign b_data = b_val_i;
    end else begin : g_low_slice
      assign b_data = b_val_i[DW-1:0];
    end
  endgenerate

  initial begin
    assert (DW <= AW) else $error("data width must not exceed address width");
  end

  always_comb begin
    hits_o.a_addr = (addr_i == a_val_i);
    hits_o.b_addr = (addr_i == b_val_i);
    hits_o.b_data = (data_i == b_data);
    hits_o.in_rng = (addr_i >= a_val_i) && (addr_i <= b_val_i);
  end

endmodule

// File: rtl/dbg_seq.sv
module dbg_seq
  import dbg_trig_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      en_i,
  input  logic      vld_i,
  input  logic [3:0] ttype_i,
  input  cmp_hits_t hits_i,
  output logic      trig_o,
  output logic      cap_o
);

  logic a_seen_q, done_q, trig_q, cap_q;
  logic fire, cap, set_a, go;

  assign go = en_i & vld_i;

  always_comb begin
    fire  = 1'b0;
    cap   = 1'b0;
    set_a = 1'b0;
    case (ttype_i)
      TT_A_ONLY:      fire = hits_i.a_addr;
      TT_A_OR_B:      fire = hits_i.a_addr | hits_i.b_addr;
      TT_A_THEN_B: begin
        fire  = hits_i.b_addr & a_seen_q;
        set_a = hits_i.a_addr;
      end
      TT_EV_B:        cap = hits_i.b_addr;
      TT_A_THEN_EV_B: begin
        fire  = hits_i.a_addr;
        set_a = hits_i.a_addr;
        cap   = hits_i.b_addr & a_seen_q;
      end
      TT_A_AND_B:     fire = hits_i.a_addr & hits_i.b_data;
      TT_A_NOT_B:     fire = hits_i.a_addr & ~hits_i.b_data;
      TT_INSIDE:      fire = hits_i.in_rng;
      TT_OUTSIDE:     fire = ~hits_i.in_rng;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_seen_q <= 1'b0;
      done_q   <= 1'b0;
      trig_q   <= 1'b0;
      cap_q    <= 1'b0;
    end else if (!en_i) begin
      a_seen_q <= 1'b0;
      done_q   <= 1'b0;
      trig_q   <= 1'b0;
      cap_q    <= 1'b0;
    end else begin
      trig_q <= go & fire & ~done_q;
      cap_q  <= go & cap;
      if (go & set_a) a_seen_q <= 1'b1;
      if (go & fire)  done_q   <= 1'b1;
    end
  end

  assign trig_o = trig_q;
  assign cap_o  = cap_q;

  AST_TRIG_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |=> !trig_o); // R3

  AST_THEN_B_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_o && $past(ttype_i) == TT_A_THEN_B) |-> $past(a_seen_q)); // R4

  AST_EVB_NO_TRIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(ttype_i) == TT_EV_B && $past(en_i)) |-> !trig_o); // R5

endmodule

// File: rtl/dbg_bkpt.sv
module dbg_bkpt (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic vld_i,
  input  logic full_i,
  input  logic to_bgnd_i,
  input  logic a_addr_i,
  input  logic b_addr_i,
  input  logic b_data_i,
  output logic bgnd_req_o,
  output logic swi_req_o
);

  logic hit;
  logic bgnd_q, swi_q;

  assign hit = full_i ? (a_addr_i & b_data_i) : (a_addr_i | b_addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bgnd_q <= 1'b0;
      swi_q  <= 1'b0;
    end else begin
      bgnd_q <= en_i & vld_i & hit & to_bgnd_i;
      swi_q  <= en_i & vld_i & hit & ~to_bgnd_i;
    end
  end

  assign bgnd_req_o = bgnd_q;
  assign swi_req_o  = swi_q;

  AST_REQ_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({bgnd_req_o, swi_req_o})); // R11

endmodule

// File: rtl/dbg_trig_unit.sv
module dbg_trig_unit
  import dbg_trig_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          arm_i,
  input  logic          brk_mode_i,
  input  logic [3:0]    trig_type_i,
  input  logic          brk_full_i,
  input  logic          brk_bgnd_i,
  input  logic [AW-1:0] cmp_a_i,
  input  logic [AW-1:0] cmp_b_i,
  input  logic          bus_vld_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] bus_data_i,
  output logic          trig_o,
  output logic          cap_o,
  output logic          bgnd_req_o,
  output logic          swi_req_o
);

  cmp_hits_t hits;

  dbg_cmp #(.AW(AW), .DW(DW)) u_cmp (
    .a_val_i (cmp_a_i),
    .b_val_i (cmp_b_i),
    .addr_i  (bus_addr_i),
    .data_i  (bus_data_i),
    .hits_o  (hits)
  );

  dbg_seq u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (arm_i & ~brk_mode_i),
    .vld_i   (bus_vld_i),
    .ttype_i (trig_type_i),
    .hits_i  (hits),
    .trig_o  (trig_o),
    .cap_o   (cap_o)
  );

  dbg_bkpt u_bkpt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (arm_i & brk_mode_i),
    .vld_i      (bus_vld_i),
    .full_i     (brk_full_i),
    .to_bgnd_i  (brk_bgnd_i),
    .a_addr_i   (hits.a_addr),
    .b_addr_i   (hits.b_addr),
    .b_data_i   (hits.b_data),
    .bgnd_req_o (bgnd_req_o),
    .swi_req_o  (swi_req_o)
  );

  AST_MODE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_o || cap_o) |-> !(bgnd_req_o || swi_req_o)); // R2

  AST_DISARM_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arm_i |=> !(trig_o || cap_o || bgnd_req_o || swi_req_o)); // R12

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_vld_i |=> !(trig_o || cap_o || bgnd_req_o || swi_req_o)); // R13

endmodule

// File: tb/dbg_trig_unit_bench.sv
module dbg_trig_unit_bench;

  localparam int AW = 16;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arm = 1'b0, brk = 1'b0, bfull = 1'b0, bbg = 1'b0, vld = 1'b0;
  logic [3:0] tt = 4'd0;
  logic [AW-1:0] a_reg = '0, b_reg = '0, addr = '0;
  logic [DW-1:0] data = '0;
  logic trig, cap, bg, swi;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dbg_trig_unit #(.AW(AW), .DW(DW)) u_dbg_trig_unit (
    .clk_i(clk), .rst_ni(rst_n), .arm_i(arm), .brk_mode_i(brk),
    .trig_type_i(tt), .brk_full_i(bfull), .brk_bgnd_i(bbg),
    .cmp_a_i(a_reg), .cmp_b_i(b_reg), .bus_vld_i(vld),
    .bus_addr_i(addr), .bus_data_i(data),
    .trig_o(trig), .cap_o(cap), .bgnd_req_o(bg), .swi_req_o(swi)
  );

  // outputs packed as {trig, cap, bgnd, swi}
  task automatic chk(input string r, input logic [3:0] exp);
    total++;
    if ({trig, cap, bg, swi} !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b", r, {trig, cap, bg, swi}, exp);
    end
  endtask

  // drive one bus cycle at a negedge, return at the next negedge
  task automatic step(input logic [AW-1:0] ad, input logic [DW-1:0] dt, input logic v);
    vld = v; addr = ad; data = dt;
    @(negedge clk);
  endtask

  task automatic bus(input string r, input logic [AW-1:0] ad, input logic [DW-1:0] dt,
                     input logic [3:0] exp);
    step(ad, dt, 1'b1);
    chk(r, exp);
  endtask

  task automatic rearm(input logic m, input logic [3:0] t, input logic [AW-1:0] av,
                       input logic [AW-1:0] bv);
    arm = 1'b0;
    step('0, '0, 1'b0);
    brk = m; tt = t; a_reg = av; b_reg = bv; arm = 1'b1;
  endtask

  task automatic t_reset;
    chk("R1 reset", 4'b0000);
  endtask

  task automatic t_a_only_or;
    rearm(0, 4'd0, 16'h1000, 16'h2000);
    bus("R3 A only, B addr", 16'h2000, 8'h00, 4'b0000);
    bus("R3 A only, A addr", 16'h1000, 8'h00, 4'b1000);
    bus("R3 A only, second A", 16'h1000, 8'h00, 4'b0000);
    rearm(0, 4'd1, 16'h1000, 16'h2000);
    bus("R3 A or B, miss", 16'h1234, 8'h00, 4'b0000);
    bus("R3 A or B, B addr", 16'h2000, 8'h00, 4'b1000);
  endtask

  task automatic t_then_b;
    rearm(0, 4'd2, 16'h1000, 16'h2000);
    bus("R4 B before A", 16'h2000, 8'h00, 4'b0000);
    bus("R4 A", 16'h1000, 8'h00, 4'b0000);
    bus("R4 B after A", 16'h2000, 8'h00, 4'b1000);
    rearm(0, 4'd2, 16'h3000, 16'h3000);
    bus("R4 A=B same cycle", 16'h3000, 8'h00, 4'b0000);
    bus("R4 A=B next cycle", 16'h3000, 8'h00, 4'b1000);
  endtask

  task automatic t_ev_b;
    rearm(0, 4'd3, 16'h1000, 16'h2000);
    bus("R5 B capture", 16'h2000, 8'h00, 4'b0100);
    bus("R5 B capture again", 16'h2000, 8'h00, 4'b0100);
    bus("R5 A ignored", 16'h1000, 8'h00, 4'b0000);
  endtask

  task automatic t_a_then_ev_b;
    rearm(0, 4'd4, 16'h1000, 16'h2000);
    bus("R6 B before A", 16'h2000, 8'h00, 4'b0000);
    bus("R6 A triggers", 16'h1000, 8'h00, 4'b1000);
    bus("R6 B capture", 16'h2000, 8'h00, 4'b0100);
    bus("R6 B capture again", 16'h2000, 8'h00, 4'b0100);
  endtask

  task automatic t_full;
    rearm(0, 4'd5, 16'h1000, 16'h0055);
    bus("R7 A and B, data off", 16'h1000, 8'h54, 4'b0000);
    bus("R7 A and B, match", 16'h1000, 8'h55, 4'b1000);
    rearm(0, 4'd6, 16'h1000, 16'h0055);
    bus("R7 A not B, data equal", 16'h1000, 8'h55, 4'b0000);
    bus("R7 A not B, wrong addr", 16'h2000, 8'h11, 4'b0000);
    bus("R7 A not B, match", 16'h1000, 8'h56, 4'b1000);
  endtask

  task automatic t_range;
    rearm(0, 4'd7, 16'h1000, 16'h1FFF);
    bus("R8 inside, below", 16'h0FFF, 8'h00, 4'b0000);
    bus("R8 inside, upper bound", 16'h1FFF, 8'h00, 4'b1000);
    rearm(0, 4'd7, 16'h1000, 16'h1FFF);
    bus("R8 inside, lower bound", 16'h1000, 8'h00, 4'b1000);
    rearm(0, 4'd8, 16'h1000, 16'h1FFF);
    bus("R8 outside, lower bound", 16'h1000, 8'h00, 4'b0000);
    bus("R8 outside, upper bound", 16'h1FFF, 8'h00, 4'b0000);
    bus("R8 outside, above", 16'h2000, 8'h00, 4'b1000);
  endtask

  task automatic t_unused;
    for (int c = 9; c < 16; c++) begin
      rearm(0, 4'(c), 16'h1000, 16'h2000);
      bus("R14 unused type A", 16'h1000, 8'h00, 4'b0000);
      bus("R14 unused type B", 16'h2000, 8'h00, 4'b0000);
    end
  endtask

  task automatic t_brk;
    rearm(1, 4'd0, 16'h1000, 16'h2000);
    bfull = 0; bbg = 1;
    bus("R9 dual, B addr", 16'h2000, 8'h00, 4'b0010);
    bus("R9 dual, A addr (R2 no trig)", 16'h1000, 8'h00, 4'b0010);
    bus("R9 dual, repeat hit", 16'h1000, 8'h00, 4'b0010);
    bus("R9 dual, miss", 16'h1234, 8'h00, 4'b0000);
    bbg = 0;
    bus("R11 swi target", 16'h1000, 8'h00, 4'b0001);
    rearm(1, 4'd3, 16'h1000, 16'h0055);
    bfull = 1; bbg = 1;
    bus("R10 full, match (R2 no cap)", 16'h1000, 8'h55, 4'b0010);
    bus("R10 full, data off", 16'h1000, 8'h54, 4'b0000);
    bus("R10 full, B addr only", 16'h0055, 8'h55, 4'b0000);
    rearm(0, 4'd0, 16'h1000, 16'h2000);
    bus("R2 debug mode, no request", 16'h1000, 8'h00, 4'b1000);
    bfull = 0; bbg = 0;
  endtask

  task automatic t_disarm;
    rearm(0, 4'd2, 16'h1000, 16'h2000);
    bus("R12 A seen", 16'h1000, 8'h00, 4'b0000);
    rearm(0, 4'd2, 16'h1000, 16'h2000);
    bus("R12 history cleared", 16'h2000, 8'h00, 4'b0000);
    rearm(0, 4'd0, 16'h1000, 16'h2000);
    arm = 0;
    bus("R12 disarmed A", 16'h1000, 8'h00, 4'b0000);
    arm = 1;
    rearm(1, 4'd0, 16'h1000, 16'h2000);
    arm = 0;
    bus("R12 disarmed breakpoint", 16'h1000, 8'h00, 4'b0000);
    arm = 1;
  endtask

  task automatic t_vld;
    rearm(0, 4'd2, 16'h1000, 16'h2000);
    step(16'h1000, 8'h00, 1'b0);
    chk("R13 invalid A", 4'b0000);
    bus("R13 B without valid A", 16'h2000, 8'h00, 4'b0000);
    rearm(0, 4'd0, 16'h1000, 16'h2000);
    step(16'h1000, 8'h00, 1'b0);
    chk("R13 invalid cycle", 4'b0000);
    bus("R13 valid A after", 16'h1000, 8'h00, 4'b1000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_a_only_or;
    t_then_b;
    t_ev_b;
    t_a_then_ev_b;
    t_full;
    t_range;
    t_unused;
    t_brk;
    t_disarm;
    t_vld;
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule